// File: doc/BRIEF.md
# Flash Command Interface Controller

This block sits between a flash device's external bus and its internals. It watches chip-enable, write-enable, output-enable, the address and a 16-bit data bus, all sampled on a system clock. A byte written on the low data lines is decoded as a command. One-write commands change the read mode or clear the status. Two-write commands start a program or block-erase operation on a separate program/erase engine. The controller also passes suspend and resume requests to that engine.

Reads are steered to one of three sources. Array mode forwards the memory array's data. Identifier mode returns fixed codes. Status mode returns the status register, which is frozen at the start of each read strobe.

Which commands are legal depends on the engine's state: idle, running a program, running an erase, program suspended, or erase suspended. A command that is not legal in the current state is dropped without any effect. The one exception is a malformed erase pair, which raises a sticky sequence-error indication. Error bits are sticky: the engine can only set them, and only a clear command removes them.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: While rp_n is low the controller is held in reset: array-read mode, all sticky bits zero and no engine request. After release, reads return arr_rdata with no command needed.
- R2: A command is taken on a rising edge of we_n while ce_n is low. A we_n pulse with ce_n high has no effect.
- R3: Writing 40h or 10h and then a second write gives one eng_start pulse with eng_erase=0. The pulse carries the address and 16-bit data of the second write, and the mode becomes status.
- R4: Writing 20h and then D0h gives one eng_start pulse with eng_erase=1 and eng_addr equal to the address of the D0h write.
- R5: If the write after 20h is not D0h, no operation starts, SR bits 5 and 4 are set, and the mode becomes status.
- R6: In status mode dq_out is {8'h00, SR} at any address. SR bit 7 is the inverse of eng_busy, bit 6 is eng_esusp, bit 2 is eng_psusp, and bit 0 is 0. Bits 5, 4, 3 and 1 are the sticky erase-error, program-error, supply-error and lock-error bits.
- R7: The status byte is captured when a read strobe (ce_n and oe_n both low) begins. It does not change while that strobe is held.
- R8: Writing 90h selects identifier mode. Address 0 reads 0089h, address 1 reads the DEV_ID parameter (default 00D4h), and any other address reads 0000h.
- R9: eng_err_set[3:0] sets sticky SR bits {5,4,3,1}, and nothing else clears them. Writing 50h in the idle state clears all four.
- R10: While an erase is running, only 70h and B0h are accepted. B0h gives one eng_suspend pulse, and any other code is ignored.
- R11: While a program is running, only 70h, B0h and D0h are accepted. D0h there issues no engine request.
- R12: With erase suspended, the accepted codes are D0h (gives eng_resume), 40h, 10h, FFh, 70h and 90h. With program suspended, the accepted codes are FFh, 70h, 90h and D0h.
- R13: FFh selects array mode. Reserved codes such as 00h, 01h, 60h, 2Fh, C0h and 98h, and D0h or B0h while idle, leave the mode and status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rp_n | input | 1 | Active-low reset/power-down |
| ce_n | input | 1 | Active-low chip enable |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output enable |
| addr | input | AW | Bus address |
| dq_in | input | 16 | Write data from the bus |
| dq_out | output | 16 | Read data to the bus |
| arr_rdata | input | 16 | Array data for the current address |
| eng_start | output | 1 | One-cycle start request to the engine |
| eng_erase | output | 1 | Operation type for the start: 1 erase, 0 program |
| eng_addr | output | AW | Latched operation address |
| eng_data | output | 16 | Latched program data |
| eng_suspend | output | 1 | One-cycle suspend request |
| eng_resume | output | 1 | One-cycle resume request |
| eng_busy | input | 1 | Engine is executing an operation |
| eng_psusp | input | 1 | Engine has a program suspended |
| eng_esusp | input | 1 | Engine has an erase suspended |
| eng_err_set | input | 4 | Pulses that set sticky SR bits {5,4,3,1} |

## Verification
A wrong read mode appears on dq_out at the very next read: array data, an identifier code and a status byte are easy to tell apart. A stale setup state stays hidden until the next write. That write then starts an operation that should not exist, or raises a sequence error, so the bench follows each refused command with a write that would expose a wrongly accepted one. Faults in the engine-state tracking show up as extra or missing suspend, resume or start pulses in the same cycles. Faults in the status latch show up as a status byte that changes while a strobe is held.

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
  parameter int          AW     = 20,
  parameter logic [15:0] MFR_ID = 16'h0089,
  parameter logic [15:0] DEV_ID = 16'h00D4
) (
  input  logic          clk,
  input  logic          rp_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   dq_in,
  output logic [15:0]   dq_out,
  input  logic [15:0]   arr_rdata,
  output logic          eng_start,
  output logic          eng_erase,
  output logic [AW-1:0] eng_addr,
  output logic [15:0]   eng_data,
  output logic          eng_suspend,
  output logic          eng_resume,
  input  logic          eng_busy,
  input  logic          eng_psusp,
  input  logic          eng_esusp,
  input  logic [3:0]    eng_err_set
);
  typedef enum logic [1:0] {M_ARR, M_ID, M_STAT} mode_t;
  typedef enum logic [1:0] {P_NONE, P_PROG, P_ERASE} pend_t;
  typedef enum logic [2:0] {E_IDLE, E_PRUN, E_ERUN, E_PSUS, E_ESUS} est_t;

  logic [1:0] we_s, ce_s, rd_s;
  logic       we_q, rd_q;
  mode_t      mode;
  pend_t      pend;
  est_t       est;
  logic       run_erase;
  logic [3:0] sr_stk;
  logic [7:0] sr, sr_lat;
  logic       ok;

  wire  [7:0] cmd    = dq_in[7:0];
  wire        wr_stb = we_s[1] & ~we_q & ~ce_s[1];
  wire        rd_rise = rd_s[1] & ~rd_q;

  always_ff @(posedge clk or negedge rp_n)
    if (!rp_n) begin
      we_s <= 2'b11; ce_s <= 2'b11; rd_s <= 2'b00;
      we_q <= 1'b1;  rd_q <= 1'b0;
    end else begin
      we_s <= {we_s[0], we_n};
      ce_s <= {ce_s[0], ce_n};
      rd_s <= {rd_s[0], ~ce_n & ~oe_n};
      we_q <= we_s[1];
      rd_q <= rd_s[1];
    end

  always_comb
    if (eng_busy)       est = run_erase ? E_ERUN : E_PRUN;
    else if (eng_psusp) est = E_PSUS;
    else if (eng_esusp) est = E_ESUS;
    else                est = E_IDLE;

  always_comb
    case (est)
      E_IDLE:  ok = cmd inside {8'hFF, 8'h40, 8'h10, 8'h20, 8'h70, 8'h50, 8'h90};
      E_PRUN:  ok = cmd inside {8'h70, 8'hB0, 8'hD0};
      E_ERUN:  ok = cmd inside {8'h70, 8'hB0};
      E_PSUS:  ok = cmd inside {8'hFF, 8'h70, 8'h90, 8'hD0};
      default: ok = cmd inside {8'hD0, 8'h40, 8'h10, 8'hFF, 8'h70, 8'h90};
    endcase

  always_ff @(posedge clk or negedge rp_n)
    if (!rp_n) begin
      mode <= M_ARR; pend <= P_NONE; run_erase <= 1'b0; sr_stk <= '0;
      eng_start <= 1'b0; eng_erase <= 1'b0; eng_addr <= '0; eng_data <= '0;
      eng_suspend <= 1'b0; eng_resume <= 1'b0;
    end else begin
      eng_start   <= 1'b0;
      eng_suspend <= 1'b0;
      eng_resume  <= 1'b0;
      sr_stk      <= sr_stk | eng_err_set;
      if (wr_stb) begin
        if (pend == P_PROG) begin
          pend <= P_NONE; mode <= M_STAT;
          eng_start <= 1'b1; eng_erase <= 1'b0; run_erase <= 1'b0;
          eng_addr <= addr; eng_data <= dq_in;
        end else if (pend == P_ERASE) begin
          pend <= P_NONE; mode <= M_STAT;
          if (cmd == 8'hD0) begin
            eng_start <= 1'b1; eng_erase <= 1'b1; run_erase <= 1'b1;
            eng_addr <= addr; eng_data <= dq_in;
          end else
            sr_stk <= sr_stk | eng_err_set | 4'b1100;
        end else if (ok) begin
          case (cmd)
            8'hFF:        mode <= M_ARR;
            8'h90:        mode <= M_ID;
            8'h70:        mode <= M_STAT;
            8'h40, 8'h10: begin pend <= P_PROG;  mode <= M_STAT; end
            8'h20:        begin pend <= P_ERASE; mode <= M_STAT; end
            8'h50:        sr_stk <= eng_err_set;
            8'hB0:        begin eng_suspend <= 1'b1; mode <= M_STAT; end
            8'hD0: begin
              mode <= M_STAT;
              if (est == E_PSUS || est == E_ESUS) begin
                eng_resume <= 1'b1;
                run_erase  <= (est == E_ESUS);
              end
            end
            default: ;
          endcase
        end
      end
    end

  assign sr = {~eng_busy, eng_esusp, sr_stk[3], sr_stk[2], sr_stk[1], eng_psusp, sr_stk[0], 1'b0};

  always_ff @(posedge clk or negedge rp_n)
    if (!rp_n)        sr_lat <= '0;
    else if (rd_rise) sr_lat <= sr;

  always_comb
    case (mode)
      M_ARR:   dq_out = arr_rdata;
      M_ID:    dq_out = (addr[AW-1:1] == '0) ? (addr[0] ? DEV_ID : MFR_ID) : 16'h0000;
      default: dq_out = {8'h00, sr_lat};
    endcase

  // R3
  req_excl_chk: assert property (@(posedge clk) disable iff (!rp_n)
    $onehot0({eng_start, eng_suspend, eng_resume}));
  // R3
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rp_n)
    eng_start |=> !eng_start);
  // R4
  erase_confirm_chk: assert property (@(posedge clk) disable iff (!rp_n)
    (eng_start && eng_erase) |-> ($past(dq_in[7:0]) == 8'hD0));
  // R10
  susp_running_chk: assert property (@(posedge clk) disable iff (!rp_n)
    eng_suspend |-> $past(eng_busy));
  // R7
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rp_n)
    (mode == M_STAT && $past(mode) == M_STAT && rd_q && $past(rd_q)) |-> $stable(dq_out));
  // R9
  sticky_clear_chk: assert property (@(posedge clk) disable iff (!rp_n)
    $fell(sr_stk[2]) |-> $past(wr_stb && dq_in[7:0] == 8'h50));
endmodule

// File: tb/sim_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_flash_cmd_ctrl;
  localparam int AW = 20;
  logic clk = 0, rp_n = 0, ce_n = 1, we_n = 1, oe_n = 1;
  logic [AW-1:0] addr = '0;
  logic [15:0] dq_in = '0, dq_out, arr_rdata;
  logic eng_start, eng_erase, eng_suspend, eng_resume;
  logic [AW-1:0] eng_addr;
  logic [15:0] eng_data;
  logic eng_busy = 0, eng_psusp = 0, eng_esusp = 0;
  logic [3:0] eng_err_set = 0;
  int checks = 0, errors = 0, n_start = 0, n_susp = 0, n_res = 0;
  logic st_er; logic [AW-1:0] st_a; logic [15:0] st_d;
  logic done = 0;

  always #10 clk = ~clk;
  assign arr_rdata = addr[15:0] ^ 16'h5A5A;

  flash_cmd_ctrl #(.AW(AW)) u0 (.*);

  always @(posedge clk) begin
    if (eng_start) begin n_start++; st_er = eng_erase; st_a = eng_addr; st_d = eng_data; end
    if (eng_suspend) n_susp++;
    if (eng_resume) n_res++;
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d, input bit ce = 1);
    @(negedge clk); addr = a; dq_in = d; ce_n = ~ce;
    @(negedge clk); we_n = 0;
    repeat (2) @(negedge clk); we_n = 1;
    repeat (4) @(negedge clk); ce_n = 1;
    @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [15:0] v);
    @(negedge clk); addr = a; ce_n = 0; oe_n = 0;
    repeat (5) @(negedge clk); v = dq_out;
    oe_n = 1; ce_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic err_pulse(input logic [3:0] m);
    @(negedge clk); eng_err_set = m;
    @(negedge clk); eng_err_set = 0;
  endtask

  function automatic logic [7:0] mask_of(input logic [3:0] m);
    return {2'b00, m[3], m[2], m[1], 1'b0, m[0], 1'b0};
  endfunction

  function automatic logic [15:0] exp_rd(input int md, input logic [AW-1:0] a, input logic [7:0] stk);
    case (md)
      0: return a[15:0] ^ 16'h5A5A;
      1: return (a == 0) ? 16'h0089 : (a == 1) ? 16'h00D4 : 16'h0000;
      default: return {8'h00, 8'h80 | stk};
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int s0, md;
    logic [7:0] stk;
    void'($urandom(32'h1F2E3D4C));
    addr = 20'h5;
    repeat (4) @(negedge clk);
    chk(dq_out, 16'h5A5F, "R1 array in reset");
    chk(eng_start, 0, "R1 no start in reset");
    rp_n = 1;
    rd(20'h123, v); chk(v, 16'h0123 ^ 16'h5A5A, "R1 array after release");
    wr(0, 16'h90, 0);
    rd(0, v); chk(v, 16'h5A5A, "R2 write with ce_n high ignored");
    wr(0, 16'h90);
    rd(0, v); chk(v, 16'h0089, "R8 manufacturer");
    rd(1, v); chk(v, 16'h00D4, "R8 device");
    rd(2, v); chk(v, 16'h0000, "R8 other address");
    wr(0, 16'h70);
    rd(20'h55, v); chk(v, 16'h0080, "R6 idle status any address");
    // program
    s0 = n_start;
    wr(0, 16'h40); wr(20'h321, 16'hBEEF);
    chk(n_start - s0, 1, "R3 one start");
    chk({st_er, st_a, st_d}, {1'b0, 20'h321, 16'hBEEF}, "R3 op addr data");
    eng_busy = 1;
    rd(7, v); chk(v, 16'h0000, "R6 busy status");
    wr(0, 16'h90); rd(0, v); chk(v, 16'h0000, "R11 90h ignored while programming");
    wr(0, 16'hD0); chk(n_res, 0, "R11 D0h no resume while running");
    wr(0, 16'hB0); chk(n_susp, 1, "R11 suspend accepted");
    eng_busy = 0; eng_psusp = 1;
    rd(0, v); chk(v, 16'h0084, "R6 program suspended status");
    wr(0, 16'h20); wr(0, 16'h77);
    rd(0, v); chk(v, 16'h0084, "R12 20h ignored in program suspend");
    wr(0, 16'h40); wr(0, 16'h1111); chk(n_start - s0, 1, "R12 40h ignored in program suspend");
    wr(0, 16'hFF); rd(7, v); chk(v, 16'h0007 ^ 16'h5A5A, "R12 array in program suspend");
    wr(0, 16'hD0); chk(n_res, 1, "R12 resume program");
    eng_psusp = 0; eng_busy = 1;
    rd(0, v); chk(v, 16'h0000, "R12 status after resume");
    err_pulse(4'b0100); eng_busy = 0;
    rd(0, v); chk(v, 16'h0090, "R9 program error sticky");
    wr(0, 16'h50); rd(0, v); chk(v, 16'h0080, "R9 clear");
    // erase
    s0 = n_start;
    wr(0, 16'h20); wr(20'h4000, 16'hD0);
    chk(n_start - s0, 1, "R4 one start");
    chk({st_er, st_a}, {1'b1, 20'h4000}, "R4 erase address");
    eng_busy = 1;
    wr(0, 16'h40); wr(0, 16'h0000);
    chk(n_start - s0, 1, "R10 40h ignored while erasing");
    wr(0, 16'hD0); chk(n_res, 1, "R10 D0h ignored while erasing");
    wr(0, 16'hFF); rd(9, v); chk(v, 16'h0000, "R10 FFh ignored while erasing");
    wr(0, 16'hB0); chk(n_susp, 2, "R10 suspend erase");
    eng_busy = 0; eng_esusp = 1;
    rd(0, v); chk(v, 16'h00C0, "R6 erase suspended status");
    wr(0, 16'h20); wr(0, 16'h33);
    rd(0, v); chk(v, 16'h00C0, "R12 20h ignored in erase suspend");
    wr(0, 16'h40); wr(20'h10, 16'h1234);
    chk(n_start - s0, 2, "R12 program in erase suspend");
    chk({st_er, st_a, st_d}, {1'b0, 20'h10, 16'h1234}, "R12 nested program op");
    eng_busy = 1;
    rd(0, v); chk(v, 16'h0040, "R6 nested program status");
    eng_busy = 0;
    wr(0, 16'hD0); chk(n_res, 2, "R12 resume erase");
    eng_esusp = 0; eng_busy = 1;
    err_pulse(4'b1001); eng_busy = 0;
    rd(0, v); chk(v, 16'h00A2, "R9 erase and lock sticky");
    wr(0, 16'h50); wr(0, 16'hFF);
    // sequence error
    s0 = n_start;
    wr(0, 16'h20); wr(0, 16'h30);
    rd(20'h77, v); chk(v, 16'h00B0, "R5 sequence error");
    chk(n_start - s0, 0, "R5 no start");
    // latch
    wr(0, 16'h50);
    @(negedge clk); ce_n = 0; oe_n = 0;
    repeat (5) @(negedge clk); chk(dq_out, 16'h0080, "R7 captured");
    eng_busy = 1;
    repeat (6) @(negedge clk); chk(dq_out, 16'h0080, "R7 held during strobe");
    oe_n = 1; ce_n = 1; repeat (3) @(negedge clk);
    rd(0, v); chk(v, 16'h0000, "R7 new value after toggle");
    eng_busy = 0;
    // reserved
    wr(0, 16'hFF);
    wr(0, 16'h60); rd(3, v); chk(v, 16'h0003 ^ 16'h5A5A, "R13 60h ignored");
    wr(0, 16'h90); wr(0, 16'h98); rd(1, v); chk(v, 16'h00D4, "R13 98h ignored");
    wr(0, 16'hB0); chk(n_susp, 2, "R13 B0h idle ignored");
    // random
    md = 1; stk = 8'h00;
    for (int i = 0; i < 60; i++) begin
      int op;
      logic [AW-1:0] a;
      op = $urandom % 7;
      case (op)
        0: begin wr(0, 16'hFF); md = 0; end
        1: begin wr(0, 16'h90); md = 1; end
        2: begin wr(0, 16'h70); md = 2; end
        3: begin wr(0, 16'h50); stk = 0; end
        4: begin
          logic [7:0] rc;
          case ($urandom % 6) 0: rc = 8'h00; 1: rc = 8'h01; 2: rc = 8'h60;
            3: rc = 8'h2F; 4: rc = 8'hC0; default: rc = 8'h98; endcase
          wr(0, {8'h00, rc});
        end
        5: begin
          logic [7:0] j;
          j = 8'($urandom); if (j == 8'hD0) j = 8'hD1;
          s0 = n_start;
          wr(0, 16'h20); wr(0, {8'h00, j});
          chk(n_start - s0, 0, "R5 random sequence error no start");
          md = 2; stk = stk | 8'h30;
        end
        default: begin
          logic [15:0] d; logic [3:0] m;
          d = 16'($urandom); m = 4'($urandom);
          a = AW'($urandom);
          s0 = n_start;
          wr(0, ($urandom % 2) ? 16'h40 : 16'h10); wr(a, d);
          chk(n_start - s0, 1, "R3 random start");
          chk({st_er, st_a, st_d}, {1'b0, a, d}, "R3 random op");
          eng_busy = 1; repeat (3) @(negedge clk);
          err_pulse(m); eng_busy = 0;
          md = 2; stk = stk | mask_of(m);
        end
      endcase
      a = ($urandom % 2) ? AW'($urandom % 4) : AW'($urandom);
      rd(a, v);
      chk(v, exp_rd(md, a, stk), "R6 R8 R9 R13 random read");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule